// File: doc/BRIEF.md
# Requester-to-Stream ID Lookup Table

This block maps the 16-bit requester ID of a PCIe transaction (bus, device, function) onto a 6-bit stream ID and a 3-bit secondary ID. An address-translation unit and an interrupt translation unit downstream both use the result. The table has 32 entries. Each entry holds a valid flag, the two output IDs, a requester-ID key and a 16-bit match mask. A mask bit of 1 means that requester-ID bit must equal the key. A mask bit of 0 makes that bit don't-care, so one entry can cover a single function or a whole range of functions.

Software never addresses an entry directly. It works through a small register window: a control register that picks an entry, and two staging registers (attributes and key). Setting the load bit in a control write copies the selected entry into the staging registers, where software can read it back. A control write with the load bit clear commits the staging registers into the selected entry. Writing zero to both staging registers and then committing removes an entry.

On the lookup side, a requester ID is compared against every valid entry in parallel. The lowest-indexed matching entry wins. The result comes back one clock after the request.

Top module: `reqid_stream_lut`

## Requirements
- R1: After a synchronous reset, every entry is invalid and the control and both staging registers read as zero.
- R2: Writing the control register (address 0) with bit 16 set loads the entry selected by bits 4:0 into both staging registers. The table itself is left unchanged.
- R3: Writing the control register with bit 16 clear commits both staging registers into the entry selected by bits 4:0. A lookup issued in the next cycle sees the new entry.
- R4: The attribute staging register (address 1) keeps only bit 31 (valid), bits 10:8 (secondary ID) and bits 5:0 (stream ID). All other bits read as zero.
- R5: The key staging register (address 2) holds the requester ID in bits 31:16 and the match mask in bits 15:0. All 32 bits read back as written.
- R6: An entry matches when, for every mask bit set to 1, the requester-ID bit equals the key bit. An all-ones mask gives an exact match and an all-zero mask matches every requester ID.
- R7: When several valid entries match, the entry with the lowest index supplies the stream ID and the secondary ID.
- R8: When no valid entry matches, the lookup returns hit low with the stream ID and secondary ID both zero.
- R9: An entry committed with its valid flag clear never matches, whatever its key. This covers an entry removed by committing zeroed staging registers.
- R10: A lookup result, marked by lk_ack, appears exactly one cycle after lk_req. With no request, lk_ack is low.
- R11: A register read returns its data one cycle after reg_rd. Address 3 reads as zero and ignores writes.
- R12: The control register reads back bit 16 and bits 4:0 of its last write, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address (0 control, 1 attributes, 2 key) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| lk_req | input | 1 | Lookup request |
| lk_rid | input | 16 | Requester ID to translate |
| lk_ack | output | 1 | Lookup result valid |
| lk_hit | output | 1 | A valid entry matched |
| lk_sid | output | 6 | Stream ID of the winning entry |
| lk_sec | output | 3 | Secondary ID of the winning entry |

## Verification
If an entry is stored wrongly, the damage shows up at the ports one cycle after the next lookup whose requester ID reaches that entry. It appears as a wrong stream ID, a missed hit or a spurious hit. The same stored state is also visible through a load followed by a read, two cycles after the load write. A wrong priority decision can only be seen when two valid entries overlap, so the bench deliberately programs a narrow entry and a wide entry that cover the same requester ID. Staging-register corruption is visible on the very next read, and it spreads into the table on the next commit.

// File: rtl/rsl_pkg.sv
package rsl_pkg;

  localparam int REGW  = 32;
  localparam int ADDRW = 2;
  localparam int RIDW  = 16;
  localparam int SIDW  = 6;
  localparam int SECW  = 3;

  // register word addresses
  localparam logic [ADDRW-1:0] A_CTRL = 2'd0;
  localparam logic [ADDRW-1:0] A_ATTR = 2'd1;
  localparam logic [ADDRW-1:0] A_KEY  = 2'd2;

  // field positions that software depends on
  localparam int LOAD_BIT = 16;
  localparam int VLD_BIT  = 31;
  localparam int SEC_LSB  = 8;
  localparam int SID_LSB  = 0;
  localparam int RID_LSB  = 16;
  localparam int MASK_LSB = 0;

  typedef struct packed {
    logic            vld;
    logic [SECW-1:0] sec;
    logic [SIDW-1:0] sid;
    logic [RIDW-1:0] rid;
    logic [RIDW-1:0] mask;
  } lut_entry_t;

endpackage

// File: rtl/rsl_regif.sv
module rsl_regif
  import rsl_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDXW    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [ADDRW-1:0] reg_addr,
  input  logic [REGW-1:0]  reg_wdata,
  output logic [REGW-1:0]  reg_rdata,
  output logic [IDXW-1:0]  acc_idx_o,
  input  lut_entry_t       rd_entry_i,
  output logic             commit_o,
  output lut_entry_t       stage_o
);

  logic            ctrl_wr, load_req;
  logic            load_q;
  logic [IDXW-1:0] idx_q;
  lut_entry_t      stage_q;
  logic [REGW-1:0] rd_mux, rdata_q;

  assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
  assign load_req  = ctrl_wr && reg_wdata[LOAD_BIT];
  assign commit_o  = ctrl_wr && !reg_wdata[LOAD_BIT];
  assign acc_idx_o = reg_wdata[IDXW-1:0];
  assign stage_o   = stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      load_q  <= 1'b0;
      idx_q   <= '0;
    end else if (ctrl_wr) begin
      load_q <= reg_wdata[LOAD_BIT];
      idx_q  <= reg_wdata[IDXW-1:0];
      if (load_req) stage_q <= rd_entry_i;
    end else if (reg_wr && reg_addr == A_ATTR) begin
      stage_q.vld <= reg_wdata[VLD_BIT];
      stage_q.sec <= reg_wdata[SEC_LSB +: SECW];
      stage_q.sid <= reg_wdata[SID_LSB +: SIDW];
    end else if (reg_wr && reg_addr == A_KEY) begin
      stage_q.rid  <= reg_wdata[RID_LSB +: RIDW];
      stage_q.mask <= reg_wdata[MASK_LSB +: RIDW];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_mux[LOAD_BIT]   = load_q;
        rd_mux[IDXW-1:0]   = idx_q;
      end
      A_ATTR: begin
        rd_mux[VLD_BIT]            = stage_q.vld;
        rd_mux[SEC_LSB +: SECW]    = stage_q.sec;
        rd_mux[SID_LSB +: SIDW]    = stage_q.sid;
      end
      A_KEY: begin
        rd_mux[RID_LSB +: RIDW]    = stage_q.rid;
        rd_mux[MASK_LSB +: RIDW]   = stage_q.mask;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= reg_rd ? rd_mux : '0;
  end

  assign reg_rdata = rdata_q;

  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_ATTR) |=> (reg_rdata[30:11] == '0 && reg_rdata[7:6] == '0));

  // R11
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0));

endmodule

// File: rtl/rsl_store.sv
module rsl_store
  import rsl_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDXW    = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            commit_i,
  input  logic [IDXW-1:0] idx_i,
  input  lut_entry_t      wr_entry_i,
  output lut_entry_t      rd_entry_o,
  output lut_entry_t      tbl_o [ENTRIES]
);

  lut_entry_t           tbl_q [ENTRIES];
  logic [ENTRIES-1:0]   vld_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        tbl_q[g] <= '0;
      else if (commit_i && idx_i == IDXW'(g))
        tbl_q[g] <= wr_entry_i;
    end
    assign tbl_o[g]   = tbl_q[g];
    assign vld_vec[g] = tbl_q[g].vld;
  end

  assign rd_entry_o = tbl_q[idx_i];

  // R3, R9
  commit_valid_chk: assert property (@(posedge clk) disable iff (rst)
    commit_i |=> (vld_vec[$past(idx_i)] == $past(wr_entry_i.vld)));

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (vld_vec == '0));

endmodule

// File: rtl/rsl_match.sv
module rsl_match
  import rsl_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  lut_entry_t      tbl_i [ENTRIES],
  input  logic            lk_req,
  input  logic [RIDW-1:0] lk_rid,
  output logic            lk_ack,
  output logic            lk_hit,
  output logic [SIDW-1:0] lk_sid,
  output logic [SECW-1:0] lk_sec
);

  logic [ENTRIES-1:0] hit_vec;
  logic               any_hit;
  lut_entry_t         win;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = tbl_i[g].vld &&
                        (((lk_rid ^ tbl_i[g].rid) & tbl_i[g].mask) == '0);
  end

  // lowest index wins: scan from the top so lower indices overwrite
  always_comb begin
    any_hit = 1'b0;
    win     = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win     = tbl_i[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_ack <= 1'b0;
      lk_hit <= 1'b0;
      lk_sid <= '0;
      lk_sec <= '0;
    end else begin
      lk_ack <= lk_req;
      lk_hit <= lk_req && any_hit;
      lk_sid <= (lk_req && any_hit) ? win.sid : '0;
      lk_sec <= (lk_req && any_hit) ? win.sec : '0;
    end
  end

  // R10
  resp_lat_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_ack);

  // R10
  hit_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_ack);

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_sid == '0 && lk_sec == '0));

endmodule

// File: rtl/reqid_stream_lut.sv
module reqid_stream_lut
  import rsl_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDXW    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [ADDRW-1:0] reg_addr,
  input  logic [REGW-1:0]  reg_wdata,
  output logic [REGW-1:0]  reg_rdata,
  input  logic             lk_req,
  input  logic [RIDW-1:0]  lk_rid,
  output logic             lk_ack,
  output logic             lk_hit,
  output logic [SIDW-1:0]  lk_sid,
  output logic [SECW-1:0]  lk_sec
);

  logic [IDXW-1:0] acc_idx;
  logic            commit;
  lut_entry_t      rd_entry, stage;
  lut_entry_t      tbl [ENTRIES];

  rsl_regif #(.ENTRIES(ENTRIES), .IDXW(IDXW)) u_regif (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .acc_idx_o  (acc_idx),
    .rd_entry_i (rd_entry),
    .commit_o   (commit),
    .stage_o    (stage)
  );

  rsl_store #(.ENTRIES(ENTRIES), .IDXW(IDXW)) u_store (
    .clk        (clk),
    .rst        (rst),
    .commit_i   (commit),
    .idx_i      (acc_idx),
    .wr_entry_i (stage),
    .rd_entry_o (rd_entry),
    .tbl_o      (tbl)
  );

  rsl_match #(.ENTRIES(ENTRIES)) u_match (
    .clk    (clk),
    .rst    (rst),
    .tbl_i  (tbl),
    .lk_req (lk_req),
    .lk_rid (lk_rid),
    .lk_ack (lk_ack),
    .lk_hit (lk_hit),
    .lk_sid (lk_sid),
    .lk_sec (lk_sec)
  );

endmodule

// File: tb/tb_reqid_stream_lut.sv
module tb_reqid_stream_lut;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_req = 1'b0;
  logic [15:0] lk_rid = '0;
  logic        lk_ack, lk_hit;
  logic [5:0]  lk_sid;
  logic [2:0]  lk_sec;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] exp_rd[$];
  string       tag_rd[$];
  logic [9:0]  exp_lk[$];
  string       tag_lk[$];
  logic        rd_seen = 1'b0, lk_seen = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  reqid_stream_lut dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req), .lk_rid(lk_rid),
    .lk_ack(lk_ack), .lk_hit(lk_hit), .lk_sid(lk_sid), .lk_sec(lk_sec)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver tasks: called at a negedge, return at the next negedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string req);
    reg_rd = 1'b1; reg_addr = a;
    exp_rd.push_back(e); tag_rd.push_back(req);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic lk(input logic [15:0] r, input bit h, input logic [5:0] s, input logic [2:0] c, input string req);
    lk_req = 1'b1; lk_rid = r;
    exp_lk.push_back({h, c, s}); tag_lk.push_back(req);
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  always @(posedge clk) begin
    rd_seen <= reg_rd;
    lk_seen <= lk_req;
  end

  // monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rd_seen && exp_rd.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_rd.pop_front(); t = tag_rd.pop_front();
        check(reg_rdata === e, t, reg_rdata, e);
      end
      if (lk_seen && exp_lk.size() > 0) begin
        logic [9:0] e;
        string t;
        e = exp_lk.pop_front(); t = tag_lk.pop_front();
        check(lk_ack === 1'b1, "R10", {31'd0, lk_ack}, 32'd1);
        check({lk_hit, lk_sec, lk_sid} === e, t, {22'd0, lk_hit, lk_sec, lk_sid}, {22'd0, e});
      end else begin
        check(lk_ack === 1'b0, "R10 idle", {31'd0, lk_ack}, 32'd0);
      end
    end
  end

  task automatic summary();
    if (exp_rd.size() != 0 || exp_lk.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_rd.size() + exp_lk.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, 32'h0, "R1 ctrl");
    rd(2'd1, 32'h0, "R1 attr");
    rd(2'd2, 32'h0, "R1 key");
    lk(16'h0100, 0, 6'h0, 3'h0, "R1 miss");
    lk(16'h0000, 0, 6'h0, 3'h0, "R8 miss zero rid");

    // R3 R6 exact entry 5
    wr(2'd1, 32'h8000_032A);
    wr(2'd2, 32'h0108_FFFF);
    wr(2'd0, 32'h0000_0005);
    lk(16'h0108, 1, 6'h2A, 3'h3, "R3 commit visible next cycle");
    lk(16'h0109, 0, 6'h0, 3'h0, "R6 exact mask rejects neighbour");

    // R4 R5 R11 R12 register fields
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h8000_073F, "R4 reserved bits drop");
    wr(2'd2, 32'h1234_ABCD);
    rd(2'd2, 32'h1234_ABCD, "R5 key readback");
    rd(2'd0, 32'h0000_0005, "R12 ctrl readback");
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'h0, "R11 unmapped");
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h0001_001F, "R12 ctrl load bit and index");
    rd(2'd1, 32'h0, "R2 load empty entry attr");
    rd(2'd2, 32'h0, "R2 load empty entry key");

    // R2 load entry 5
    wr(2'd0, 32'h0001_0005);
    rd(2'd1, 32'h8000_032A, "R2 load attr");
    rd(2'd2, 32'h0108_FFFF, "R2 load key");
    lk(16'h0108, 1, 6'h2A, 3'h3, "R2 load leaves table");

    // R6 masked entry 9
    wr(2'd1, 32'h8000_0111);
    wr(2'd2, 32'h0300_FF00);
    wr(2'd0, 32'h0000_0009);
    lk(16'h03A7, 1, 6'h11, 3'h1, "R6 masked hit");
    lk(16'h0400, 0, 6'h0, 3'h0, "R6 masked miss");

    // R7 priority with overlapping entries 2, 9, 31
    wr(2'd1, 32'h8000_0007);
    wr(2'd2, 32'h0300_FFF0);
    wr(2'd0, 32'h0000_0002);
    wr(2'd1, 32'h8000_073F);
    wr(2'd2, 32'h0000_0000);
    wr(2'd0, 32'h0000_001F);
    lk(16'h0305, 1, 6'h07, 3'h0, "R7 lowest index wins");
    lk(16'h0315, 1, 6'h11, 3'h1, "R7 only wide entry");
    lk(16'h7777, 1, 6'h3F, 3'h7, "R6 zero mask catch-all");
    lk(16'h0108, 1, 6'h2A, 3'h3, "R7 entry 5 over 31");

    // R9 removal
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h0000_0002);
    lk(16'h0305, 1, 6'h11, 3'h1, "R9 removed entry falls through");
    wr(2'd0, 32'h0001_0002);
    rd(2'd1, 32'h0, "R9 removed entry reads invalid");
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h0000_001F);
    wr(2'd0, 32'h0000_0005);
    lk(16'h7777, 0, 6'h0, 3'h0, "R8 miss after removal");
    lk(16'h0108, 0, 6'h0, 3'h0, "R9 removed exact entry");

    // R9 invalid entry with live key
    wr(2'd1, 32'h0000_0015);
    wr(2'd2, 32'h0500_FFFF);
    wr(2'd0, 32'h0000_000C);
    lk(16'h0500, 0, 6'h0, 3'h0, "R9 valid flag clear");
    lk(16'h03FF, 1, 6'h11, 3'h1, "R10 back-to-back lookup");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
  end

endmodule